// File: doc/BRIEF.md
# Legacy DMA Channel Register File

This block holds the programming state of a four-channel legacy DMA controller. Software reaches it through byte-wide I/O strobes. Each channel has a 16-bit base address and a 16-bit base count. Both are written and read one byte at a time, and a single low/high byte pointer is shared by every channel. Each channel also keeps an 8-bit page register and a 7-bit high-page register. Together with the current address, these form the physical address that a transfer engine drives.

The transfer engine reports progress through a count-advance input. The register file never stores the address and count that software reads back. It computes them from the current address, the base count and the units moved so far. A parameter selects a byte-wide controller (`WSHIFT`=0) or a word-wide controller (`WSHIFT`=1). In the word-wide case, port offsets are shifted left by one and addresses and counts are scaled by two. A query port returns the physical address and the total transfer length of any channel.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset, every base, current, progress, page and high-page register is zero, and the byte pointer points at the low byte.
- R2: A channel port index is `ch_ofs >> WSHIFT`. Its bit 0 selects address (0) or count (1), and its bits 2:1 select the channel. An access to one channel leaves the other channels unchanged.
- R3: Every channel read or write uses the low byte when the pointer is 0 and the high byte when it is 1. The pointer toggles after each channel access.
- R4: A control write whose index `ctl_ofs >> WSHIFT` equals 0xC returns the pointer to the low byte. A control write to any other index leaves the pointer unchanged.
- R5: Writing the high byte of a channel's base address or base count initialises that channel. The current address becomes the base address shifted left by `WSHIFT`, and the progress becomes zero.
- R6: Address readback is (current address + progress) when the channel's `mode_dir` bit is 0. It is (current address − progress) when that bit is 1. The result is taken modulo 2^(16+WSHIFT) and then shifted right by `WSHIFT`.
- R7: Count readback is ((base count << WSHIFT) − progress) >> WSHIFT.
- R8: A pulse on `adv_en` adds `adv_units` to the progress of channel `adv_ch`.
- R9: Page offsets 1, 2, 3 and 7 select channels 2, 3, 1 and 0. Writes to any other page offset are ignored, and reads from such an offset return zero.
- R10: The high-page register keeps only bits 6:0 of the written byte and reads back with bit 7 clear. It uses the same offset mapping as the page register. With `HPAGE_EN`=0, its writes are ignored and its reads return zero.
- R11: `q_phys` is the high page in bits 30:24, ORed with the page in bits 23:16, ORed with the current address in the low bits. `q_len` is (base count + 1) << `WSHIFT`.
- R12: Read data is registered. It appears one cycle after a read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_wr | input | 1 | Channel register write strobe |
| ch_rd | input | 1 | Channel register read strobe |
| ch_ofs | input | 3+WSHIFT | Raw channel port offset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_ofs | input | 4+WSHIFT | Raw control port offset |
| pg_wr | input | 1 | Page register write strobe |
| pg_rd | input | 1 | Page register read strobe |
| hpg_wr | input | 1 | High-page register write strobe |
| hpg_rd | input | 1 | High-page register read strobe |
| pg_ofs | input | 3 | Page / high-page port offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| mode_dir | input | 4 | Per-channel direction: 1 means decrementing |
| adv_en | input | 1 | Count-advance pulse from the transfer engine |
| adv_ch | input | 2 | Channel being advanced |
| adv_units | input | 16+WSHIFT | Units added to the progress |
| q_ch | input | 2 | Channel selected for the query outputs |
| q_phys | output | HPAGE_W+24 | Physical address of the queried channel |
| q_len | output | 17+WSHIFT | Total transfer length of the queried channel |

## Verification
Register writes, byte-pointer changes and count advances take effect at the clock edge that samples the strobe. A read strobe issued in the next cycle therefore sees the new state, and its byte lands in `rdata` at that read's own edge, one cycle after the strobe. The query outputs are combinational, so they reflect a channel's state in the same cycle as the edge that changed it. The bench drives each strobe for one cycle from a falling edge. It samples `rdata` at the following falling edge, and it samples query outputs a short delay after changing `q_ch`. To exercise the hold half of R12, it also leaves `rdata` untouched across idle cycles.

// File: rtl/dma_chan_regfile_pkg.sv
// Shared constants, types and the page-offset decode for the DMA channel
// register file. Assumes exactly four channels, which the page mapping fixes.
package dma_chan_regfile_pkg;

    localparam int CH_N    = 4;
    localparam int CH_W    = 2;
    localparam int REG_W   = 16;
    localparam int PAGE_W  = 8;
    localparam logic [3:0] CTL_IDX_FF_CLEAR = 4'hC;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } page_sel_t;

    // Map a page port offset to its channel; unmapped offsets miss.
    function automatic page_sel_t page_decode(input logic [2:0] ofs);
        page_sel_t s;
        case (ofs)
            3'd1:    s = '{hit: 1'b1, ch: 2'd2};
            3'd2:    s = '{hit: 1'b1, ch: 2'd3};
            3'd3:    s = '{hit: 1'b1, ch: 2'd1};
            3'd7:    s = '{hit: 1'b1, ch: 2'd0};
            default: s = '{hit: 1'b0, ch: 2'd0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_crf_byteptr.sv
// Shared low/high byte pointer. It toggles on every channel access and is
// forced low by a clear. Assumes clear and access are never requested in
// the same cycle; if they are, the clear wins.
module dma_crf_byteptr (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic clr,
    output logic ff
);

    // Pointer state: reset low, clear low, otherwise flip on each access.
    always_ff @(posedge clk) begin
        if (!rst_n)   ff <= 1'b0;
        else if (clr) ff <= 1'b0;
        else if (acc) ff <= ~ff;
    end

    AST_FF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ff); // R4
    AST_FF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr) |=> (ff != $past(ff))); // R3
    AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(ff)); // R3

endmodule

// File: rtl/dma_crf_chan.sv
// One DMA channel's registers: base address and count, current address,
// progress, page and high page. Produces the computed readback words, the
// physical address and the transfer length. Assumes at most one byte write
// per cycle; an initialisation in the same cycle as an advance wins.
module dma_crf_chan
    import dma_chan_regfile_pkg::*;
#(
    parameter int WSHIFT  = 0,
    parameter int HPAGE_W = 7,
    localparam int CUR_W  = REG_W + WSHIFT,
    localparam int LEN_W  = REG_W + 1 + WSHIFT,
    localparam int PHYS_W = HPAGE_W + PAGE_W + REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               sel_cnt,
    input  logic               hi,
    input  logic [7:0]         wdata,
    input  logic               dir,
    input  logic               adv_en,
    input  logic [CUR_W-1:0]   adv_units,
    input  logic               page_we,
    input  logic               hpage_we,
    output logic [REG_W-1:0]   addr_rb,
    output logic [REG_W-1:0]   cnt_rb,
    output logic [PAGE_W-1:0]  page,
    output logic [HPAGE_W-1:0] hpage,
    output logic [PHYS_W-1:0]  phys,
    output logic [LEN_W-1:0]   len
);

    logic [REG_W-1:0] base_a, base_c, old_word, merged, next_base_a;
    logic [CUR_W-1:0] cur, prog, addr_sum, cnt_full;
    logic             init;

    // Merge the incoming byte into the addressed base word.
    always_comb begin
        old_word    = sel_cnt ? base_c : base_a;
        merged      = hi ? {wdata, old_word[7:0]} : {old_word[15:8], wdata};
        next_base_a = (wr_en && !sel_cnt) ? merged : base_a;
        init        = wr_en && hi;
    end

    // Base register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_a <= '0;
            base_c <= '0;
        end else if (wr_en) begin
            if (sel_cnt) base_c <= merged;
            else         base_a <= merged;
        end
    end

    // Current address and progress: loaded on init, advanced by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            prog <= '0;
        end else if (init) begin
            cur  <= CUR_W'(next_base_a) << WSHIFT;
            prog <= '0;
        end else if (adv_en) begin
            prog <= prog + adv_units;
        end
    end

    // Page and high-page storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page  <= '0;
            hpage <= '0;
        end else begin
            if (page_we)  page  <= wdata;
            if (hpage_we) hpage <= wdata[HPAGE_W-1:0];
        end
    end

    // Readback and query values computed from the live state.
    always_comb begin
        addr_sum = dir ? (cur - prog) : (cur + prog);
        cnt_full = (CUR_W'(base_c) << WSHIFT) - prog;
        addr_rb  = REG_W'(addr_sum >> WSHIFT);
        cnt_rb   = REG_W'(cnt_full >> WSHIFT);
        len      = (LEN_W'(base_c) + LEN_W'(1)) << WSHIFT;
        phys     = {hpage, page, {REG_W{1'b0}}} | PHYS_W'(cur);
    end

    AST_INIT_ZERO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (prog == '0)); // R5
    AST_ADV_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !init) |=> (prog == $past(prog) + $past(adv_units))); // R8
    AST_CUR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> $stable(cur)); // R5

endmodule

// File: rtl/dma_chan_regfile.sv
// Top of the legacy DMA channel register file. Decodes the channel, control
// and page strobes and routes them to four channel slices. It owns the shared
// byte pointer and registers the read data. Assumes that at most one
// strobe is active in any cycle.
module dma_chan_regfile
    import dma_chan_regfile_pkg::*;
#(
    parameter int WSHIFT   = 0,
    parameter bit HPAGE_EN = 1'b1,
    parameter int HPAGE_W  = 7,
    localparam int OFS_W   = 3 + WSHIFT,
    localparam int CTL_W   = 4 + WSHIFT,
    localparam int CUR_W   = REG_W + WSHIFT,
    localparam int LEN_W   = REG_W + 1 + WSHIFT,
    localparam int PHYS_W  = HPAGE_W + PAGE_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_wr,
    input  logic              ch_rd,
    input  logic [OFS_W-1:0]  ch_ofs,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_ofs,
    input  logic              pg_wr,
    input  logic              pg_rd,
    input  logic              hpg_wr,
    input  logic              hpg_rd,
    input  logic [2:0]        pg_ofs,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [CH_N-1:0]   mode_dir,
    input  logic              adv_en,
    input  logic [CH_W-1:0]   adv_ch,
    input  logic [CUR_W-1:0]  adv_units,
    input  logic [CH_W-1:0]   q_ch,
    output logic [PHYS_W-1:0] q_phys,
    output logic [LEN_W-1:0]  q_len
);

    logic [2:0]         ch_idx;
    logic [3:0]         ctl_idx;
    logic               sel_cnt, ff, ff_clr;
    logic [CH_W-1:0]    ch_sel;
    page_sel_t          psel;
    logic [REG_W-1:0]   addr_rb  [CH_N];
    logic [REG_W-1:0]   cnt_rb   [CH_N];
    logic [PAGE_W-1:0]  page_q   [CH_N];
    logic [HPAGE_W-1:0] hpage_q  [CH_N];
    logic [PHYS_W-1:0]  phys_q   [CH_N];
    logic [LEN_W-1:0]   len_q    [CH_N];
    logic [REG_W-1:0]   ch_word;
    logic [7:0]         ch_byte, pg_byte, hpg_byte;
    logic               hpg_hit;

    // Port index decode for the channel and control spaces.
    always_comb begin
        ch_idx  = 3'(ch_ofs >> WSHIFT);
        ctl_idx = 4'(ctl_ofs >> WSHIFT);
        sel_cnt = ch_idx[0];
        ch_sel  = ch_idx[2:1];
        ff_clr  = ctl_wr && (ctl_idx == CTL_IDX_FF_CLEAR);
        psel    = page_decode(pg_ofs);
    end

    dma_crf_byteptr u_byteptr (
        .clk  (clk),
        .rst_n(rst_n),
        .acc  (ch_wr || ch_rd),
        .clr  (ff_clr),
        .ff   (ff)
    );

    // High-page support is present or strapped off by parameter.
    generate
        if (HPAGE_EN) begin : g_hpage
            assign hpg_hit = psel.hit;
        end else begin : g_no_hpage
            assign hpg_hit = 1'b0;
        end
    endgenerate

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        dma_crf_chan #(.WSHIFT(WSHIFT), .HPAGE_W(HPAGE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr && (ch_sel == CH_W'(g))),
            .sel_cnt  (sel_cnt),
            .hi       (ff),
            .wdata    (wdata),
            .dir      (mode_dir[g]),
            .adv_en   (adv_en && (adv_ch == CH_W'(g))),
            .adv_units(adv_units),
            .page_we  (pg_wr && psel.hit && (psel.ch == CH_W'(g))),
            .hpage_we (hpg_wr && hpg_hit && (psel.ch == CH_W'(g))),
            .addr_rb  (addr_rb[g]),
            .cnt_rb   (cnt_rb[g]),
            .page     (page_q[g]),
            .hpage    (hpage_q[g]),
            .phys     (phys_q[g]),
            .len      (len_q[g])
        );
    end

    // Read byte selection for each read port.
    always_comb begin
        ch_word  = sel_cnt ? cnt_rb[ch_sel] : addr_rb[ch_sel];
        ch_byte  = ff ? ch_word[15:8] : ch_word[7:0];
        pg_byte  = psel.hit ? page_q[psel.ch] : 8'h00;
        hpg_byte = hpg_hit ? 8'(hpage_q[psel.ch]) : 8'h00;
        q_phys   = phys_q[q_ch];
        q_len    = len_q[q_ch];
    end

    // Registered read data, updated only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= 8'h00;
        else if (ch_rd)  rdata <= ch_byte;
        else if (pg_rd)  rdata <= pg_byte;
        else if (hpg_rd) rdata <= hpg_byte;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_wr, ch_rd, ctl_wr, pg_wr, pg_rd, hpg_wr, hpg_rd})); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_rd || pg_rd || hpg_rd) |=> $stable(rdata)); // R12
    AST_BAD_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((pg_rd || hpg_rd) && !psel.hit) |=> (rdata == 8'h00)); // R9

endmodule

// File: tb/dma_chan_regfile_bench.sv
// Directed bench for the DMA channel register file, word-wide variant.
module dma_chan_regfile_bench;

    localparam int WS     = 1;
    localparam int CUR_W  = 16 + WS;
    localparam int LEN_W  = 17 + WS;
    localparam int PHYS_W = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch_wr = 0, ch_rd = 0, ctl_wr = 0, pg_wr = 0, pg_rd = 0, hpg_wr = 0, hpg_rd = 0;
    logic [3:0] ch_ofs = '0;
    logic [4:0] ctl_ofs = '0;
    logic [2:0] pg_ofs = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] mode_dir = '0;
    logic adv_en = 0;
    logic [1:0] adv_ch = '0, q_ch = '0;
    logic [CUR_W-1:0] adv_units = '0;
    logic [PHYS_W-1:0] q_phys;
    logic [LEN_W-1:0] q_len;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] m_ba [4], m_bc [4];
    logic [CUR_W-1:0] m_cur [4], m_prog [4];
    logic m_ff;

    always #5 clk = ~clk;

    dma_chan_regfile #(.WSHIFT(WS)) u_dma_chan_regfile (
        .clk(clk), .rst_n(rst_n), .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_ofs(ch_ofs),
        .ctl_wr(ctl_wr), .ctl_ofs(ctl_ofs), .pg_wr(pg_wr), .pg_rd(pg_rd),
        .hpg_wr(hpg_wr), .hpg_rd(hpg_rd), .pg_ofs(pg_ofs), .wdata(wdata),
        .rdata(rdata), .mode_dir(mode_dir), .adv_en(adv_en), .adv_ch(adv_ch),
        .adv_units(adv_units), .q_ch(q_ch), .q_phys(q_phys), .q_len(q_len)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ch_write(input int idx, input logic [7:0] d);
        int c;
        c = idx >> 1;
        ch_ofs = 4'(idx << WS); wdata = d; ch_wr = 1;
        @(negedge clk); ch_wr = 0;
        if (idx & 1) m_bc[c] = m_ff ? {d, m_bc[c][7:0]} : {m_bc[c][15:8], d};
        else         m_ba[c] = m_ff ? {d, m_ba[c][7:0]} : {m_ba[c][15:8], d};
        if (m_ff) begin
            m_cur[c]  = CUR_W'(m_ba[c]) << WS;
            m_prog[c] = '0;
        end
        m_ff = ~m_ff;
    endtask

    task automatic ch_read(input int idx, output logic [7:0] v);
        ch_ofs = 4'(idx << WS); ch_rd = 1;
        @(negedge clk); ch_rd = 0;
        v = rdata;
        m_ff = ~m_ff;
    endtask

    task automatic ctl_write(input logic [3:0] idx);
        ctl_ofs = 5'(idx) << WS; ctl_wr = 1;
        @(negedge clk); ctl_wr = 0;
        if (idx == 4'hC) m_ff = 1'b0;
    endtask

    task automatic pg_access(input bit high, input bit wr, input logic [2:0] ofs,
                             input logic [7:0] d, output logic [7:0] v);
        pg_ofs = ofs; wdata = d;
        if (high) begin hpg_wr = wr; hpg_rd = !wr; end
        else      begin pg_wr = wr;  pg_rd = !wr;  end
        @(negedge clk);
        pg_wr = 0; pg_rd = 0; hpg_wr = 0; hpg_rd = 0;
        v = rdata;
    endtask

    function automatic logic [15:0] exp_addr(input int c, input bit dir);
        logic [CUR_W-1:0] s;
        s = dir ? m_cur[c] - m_prog[c] : m_cur[c] + m_prog[c];
        return 16'(s >> WS);
    endfunction

    function automatic logic [15:0] exp_cnt(input int c);
        logic [CUR_W-1:0] s;
        s = (CUR_W'(m_bc[c]) << WS) - m_prog[c];
        return 16'(s >> WS);
    endfunction

    // Read both bytes of address and count of channel c and compare.
    task automatic check_words(input int c, input bit dir, input string req);
        logic [7:0] lo, hi;
        ctl_write(4'hC);
        ch_read(c * 2, lo); ch_read(c * 2, hi);
        check({req, " addr"}, {hi, lo}, exp_addr(c, dir));
        ch_read(c * 2 + 1, lo); ch_read(c * 2 + 1, hi);
        check({req, " count"}, {hi, lo}, exp_cnt(c));
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int c = 0; c < 4; c++) begin
            m_ba[c] = 0; m_bc[c] = 0; m_cur[c] = 0; m_prog[c] = 0;
        end
        m_ff = 0;
        ch_read(0, v); check("R1 addr low after reset", v, 8'h00);
        ch_read(0, v); check("R1 addr high after reset", v, 8'h00);
        pg_access(0, 0, 3'd7, 8'h00, v); check("R1 page after reset", v, 8'h00);
        q_ch = 2'd3; #1;
        check("R1 phys after reset", q_phys, '0);
        check("R1 len after reset", q_len, LEN_W'(2));
    endtask

    task automatic t_program;
        ctl_write(4'hC);
        ch_write(2, 8'h34); ch_write(2, 8'h12);
        ch_write(3, 8'h10); ch_write(3, 8'h00);
        check_words(1, 0, "R5 R2 program ch1");
    endtask

    task automatic t_decode;
        ctl_write(4'hC);
        ch_write(6, 8'hEF); ch_write(6, 8'hBE);
        ch_write(7, 8'h00); ch_write(7, 8'h01);
        check_words(3, 0, "R2 ch3");
        check_words(1, 0, "R2 ch1 untouched");
    endtask

    task automatic t_advance;
        adv_ch = 2'd1; adv_units = CUR_W'(6); adv_en = 1;
        @(negedge clk); adv_en = 0;
        m_prog[1] = m_prog[1] + CUR_W'(6);
        check_words(1, 0, "R8 R6 R7 increment dir");
        mode_dir = 4'b0010;
        check_words(1, 1, "R6 decrement dir");
        mode_dir = 4'b0000;
    endtask

    task automatic t_byteptr;
        logic [7:0] v;
        ctl_write(4'hC);
        ch_read(2, v); check("R3 first byte is low", v, exp_addr(1, 0)[7:0]);
        ch_read(2, v); check("R3 second byte is high", v, exp_addr(1, 0)[15:8]);
        ch_read(2, v);
        ctl_write(4'hB);
        ch_read(2, v); check("R4 other control keeps pointer", v, exp_addr(1, 0)[15:8]);
        ch_read(2, v);
        ctl_write(4'hC);
        ch_read(2, v); check("R4 clear gives low byte", v, exp_addr(1, 0)[7:0]);
    endtask

    task automatic t_page;
        logic [7:0] v;
        logic [7:0] exp;
        for (int o = 0; o < 8; o++) pg_access(0, 1, 3'(o), 8'(8'hA0 + o), v);
        for (int o = 0; o < 8; o++) begin
            pg_access(0, 0, 3'(o), 8'h00, v);
            exp = (o == 1 || o == 2 || o == 3 || o == 7) ? 8'(8'hA0 + o) : 8'h00;
            check($sformatf("R9 page ofs %0d", o), v, exp);
        end
        q_ch = 2'd0; #1; check("R9 ofs7 drives ch0", q_phys[23:16], 8'hA7);
        q_ch = 2'd2; #1; check("R9 ofs1 drives ch2", q_phys[23:16], 8'hA1);
    endtask

    task automatic t_hpage;
        logic [7:0] v;
        pg_access(1, 1, 3'd3, 8'hFF, v);
        pg_access(1, 0, 3'd3, 8'h00, v); check("R10 high page 7 bits", v, 8'h7F);
        pg_access(1, 1, 3'd0, 8'h55, v);
        pg_access(1, 0, 3'd0, 8'h00, v); check("R10 bad high page offset", v, 8'h00);
    endtask

    task automatic t_query;
        logic [PHYS_W-1:0] exp;
        q_ch = 2'd1; #1;
        exp = (PHYS_W'(7'h7F) << 24) | (PHYS_W'(8'hA3) << 16) | PHYS_W'(m_cur[1]);
        check("R11 phys ch1", q_phys, exp);
        check("R11 len ch1", q_len, (LEN_W'(m_bc[1]) + 1) << WS);
        q_ch = 2'd3; #1;
        check("R11 len ch3", q_len, (LEN_W'(m_bc[3]) + 1) << WS);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        pg_access(0, 0, 3'd2, 8'h00, v);
        check("R12 read data next cycle", v, 8'hA2);
        repeat (3) @(negedge clk);
        check("R12 read data holds", rdata, 8'hA2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_program; t_decode; t_advance; t_byteptr;
        t_page; t_hpage; t_query; t_hold;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule